// File: doc/BRIEF.md
# Pin Interrupt Detector

This block watches one port of up to 32 already-synchronous input pins and turns selected pin activity into two interrupt lines. Each pin is set up with two configuration bits: a kind bit choosing between level sensing and edge sensing, and a sense bit choosing the active polarity. For level sensing that polarity is high or low. For edge sensing it is rising or falling.

Every pin has its own status bit in each of two independent status vectors, one per interrupt line. A separate per-pin enable mask for each line decides which status bits reach that line and which ones appear when software reads the status back. Edge events are held until software clears them by writing ones. Level conditions are reported for as long as the pin stays at the active level.

Software reaches the block through a small register bus. The bus has a write strobe, a 4-bit register select and a registered read-data path that returns the selected register one cycle after the select is presented.

Top module: `pin_irq_unit`

## Requirements
- R1: After synchronous reset, the kind, sense, both enable masks and both status vectors read 0, and irq_a and irq_b are 0.
- R2: A kind bit of 0 (register select 0) puts that pin in level mode. A sense bit of 0 (select 1) makes a high pin active, and a sense bit of 1 makes a low pin active.
- R3: A kind bit of 1 puts that pin in edge mode. A sense bit of 0 sets the status bit on a rising edge and a sense bit of 1 sets it on a falling edge, comparing the pin with its value one cycle earlier. No other transition sets the bit.
- R4: In edge mode a status bit, once set, stays set after the pin returns to its former level, until it is cleared.
- R5: Writing to status select 8 (line A) or 9 (line B) clears each status bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R6: In level mode the status bit follows the active condition one cycle later. A write-1 clear has no lasting effect while the pin is still active, and the bit drops once the pin leaves the active level.
- R7: If an edge is detected in the same cycle as a write-1 clear of that bit, the bit ends up set.
- R8: Enable masks: selects 2 (A) and 3 (B) write the whole mask and read it back. Selects 4 and 6 OR the data into mask A and mask B, selects 5 and 7 clear the data's one bits from A and B, and these four selects read as 0.
- R9: A status read returns the status vector ANDed with that line's enable mask. Status bits are recorded whether or not the pin is enabled.
- R10: Each interrupt output is registered and equals, one cycle later, the OR of its line's enabled status bits.
- R11: Lines A and B have separate enables and status. Enabling, triggering or clearing on one line leaves the other line's output and read-back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | NUM_PINS | Synchronous pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register select |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Registered read data for the select of the previous cycle |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
The bench covers the cases where edge and level handling part ways. A held edge must survive the pin falling back, which a design storing the level would lose. A clear must be futile against a still-active level, which a design treating both kinds alike would wrongly honour. An edge coinciding with a clear must win, and a design that evaluated the clear last would drop that event. The bench also records an event on a disabled pin and then enables it, which exposes a design that gates the status at capture rather than at read, and it drives one line while watching the other, which catches any sharing between A and B.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int SEL_W     = 4;
  localparam int IRQ_LINES = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_MODE   = 4'd0,
    SEL_POL    = 4'd1,
    SEL_EN_A   = 4'd2,
    SEL_EN_B   = 4'd3,
    SEL_SET_A  = 4'd4,
    SEL_CLR_A  = 4'd5,
    SEL_SET_B  = 4'd6,
    SEL_CLR_B  = 4'd7,
    SEL_STAT_A = 4'd8,
    SEL_STAT_B = 4'd9
  } reg_sel_e;

  // Per-line register selects, derived from line index k
  function automatic logic [SEL_W-1:0] sel_en(input int k);
    return SEL_W'(SEL_EN_A) + SEL_W'(k);
  endfunction

  function automatic logic [SEL_W-1:0] sel_set(input int k);
    return SEL_W'(SEL_SET_A) + SEL_W'(2 * k);
  endfunction

  function automatic logic [SEL_W-1:0] sel_clr(input int k);
    return SEL_W'(SEL_CLR_A) + SEL_W'(2 * k);
  endfunction

  function automatic logic [SEL_W-1:0] sel_stat(input int k);
    return SEL_W'(SEL_STAT_A) + SEL_W'(k);
  endfunction
endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [SEL_W-1:0]    bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] mode_q,
  output logic [NUM_PINS-1:0] pol_q,
  output logic [NUM_PINS-1:0] en_q     [IRQ_LINES],
  output logic [NUM_PINS-1:0] clr_mask [IRQ_LINES]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      pol_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == SEL_MODE) mode_q <= bus_wdata;
      if (bus_addr == SEL_POL)  pol_q  <= bus_wdata;
    end
  end

  for (genvar k = 0; k < IRQ_LINES; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[k] <= '0;
      end else if (bus_wr) begin
        if (bus_addr == sel_en(k))       en_q[k] <= bus_wdata;
        else if (bus_addr == sel_set(k)) en_q[k] <= en_q[k] | bus_wdata;
        else if (bus_addr == sel_clr(k)) en_q[k] <= en_q[k] & ~bus_wdata;
      end
    end

    always_comb begin
      clr_mask[k] = '0;
      if (bus_wr && (bus_addr == sel_stat(k))) clr_mask[k] = bus_wdata;
    end
  end

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_in,
  input  logic [NUM_PINS-1:0] mode_q,
  input  logic [NUM_PINS-1:0] pol_q,
  output logic [NUM_PINS-1:0] edge_hit,
  output logic [NUM_PINS-1:0] level_act
);

  logic [NUM_PINS-1:0] prev_q;
  logic                primed_q;
  logic [NUM_PINS-1:0] rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pins_in;
      primed_q <= 1'b1;
    end
  end

  assign rise = pins_in & ~prev_q;
  assign fall = ~pins_in & prev_q;

  // No edge until a previous sample exists after reset
  assign edge_hit  = primed_q ? (mode_q & ((~pol_q & rise) | (pol_q & fall))) : '0;
  assign level_act = ~mode_q & (pins_in ^ pol_q);

endmodule

// File: rtl/pin_irq_flags.sv
module pin_irq_flags #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] mode_q,
  input  logic [NUM_PINS-1:0] edge_hit,
  input  logic [NUM_PINS-1:0] level_act,
  input  logic [NUM_PINS-1:0] clr_mask,
  input  logic [NUM_PINS-1:0] en_q,
  output logic [NUM_PINS-1:0] stat_q,
  output logic                irq_q
);

  logic [NUM_PINS-1:0] stat_next;

  // Edge pins: sticky, clear applied before set so a fresh edge wins
  // Level pins: follow the active condition
  always_comb begin
    stat_next = (mode_q & ((stat_q & ~clr_mask) | edge_hit)) | (~mode_q & level_act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_next;
      irq_q  <= |(stat_q & en_q);
    end
  end

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_in,
  input  logic                bus_wr,
  input  logic [SEL_W-1:0]    bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  output logic                irq_a,
  output logic                irq_b
);

  logic [NUM_PINS-1:0] mode_q, pol_q;
  logic [NUM_PINS-1:0] en_q     [IRQ_LINES];
  logic [NUM_PINS-1:0] clr_mask [IRQ_LINES];
  logic [NUM_PINS-1:0] stat_q   [IRQ_LINES];
  logic [IRQ_LINES-1:0] irq_q;
  logic [NUM_PINS-1:0] edge_hit, level_act;
  logic [NUM_PINS-1:0] rd_next;

  pin_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .mode_q   (mode_q),
    .pol_q    (pol_q),
    .en_q     (en_q),
    .clr_mask (clr_mask)
  );

  pin_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .pins_in  (pins_in),
    .mode_q   (mode_q),
    .pol_q    (pol_q),
    .edge_hit (edge_hit),
    .level_act(level_act)
  );

  for (genvar k = 0; k < IRQ_LINES; k++) begin : g_flags
    pin_irq_flags #(.NUM_PINS(NUM_PINS)) u_flags (
      .clk      (clk),
      .rst      (rst),
      .mode_q   (mode_q),
      .edge_hit (edge_hit),
      .level_act(level_act),
      .clr_mask (clr_mask[k]),
      .en_q     (en_q[k]),
      .stat_q   (stat_q[k]),
      .irq_q    (irq_q[k])
    );
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == SEL_MODE) rd_next = mode_q;
    if (bus_addr == SEL_POL)  rd_next = pol_q;
    for (int k = 0; k < IRQ_LINES; k++) begin
      if (bus_addr == sel_en(k))   rd_next = en_q[k];
      if (bus_addr == sel_stat(k)) rd_next = stat_q[k] & en_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign irq_a = irq_q[0];
  assign irq_b = irq_q[1];

endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] pins_in,
  input logic [NUM_PINS-1:0] mode_q,
  input logic [NUM_PINS-1:0] pol_q,
  input logic [NUM_PINS-1:0] edge_hit,
  input logic [NUM_PINS-1:0] clr_a,
  input logic [NUM_PINS-1:0] stat_a,
  input logic [NUM_PINS-1:0] stat_b,
  input logic [NUM_PINS-1:0] en_a,
  input logic [NUM_PINS-1:0] en_b,
  input logic                irq_a,
  input logic                irq_b
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_a && !irq_b));

  // R4
  sticky_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (($past(stat_a & mode_q & ~clr_a) & ~stat_a) == '0));

  // R6
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((($past(~mode_q & (pins_in ^ pol_q)) ^ stat_a) & $past(~mode_q)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (($past(edge_hit) & ~stat_a) == '0));

  // R10
  irq_a_or_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq_a == (|$past(stat_a & en_a))));

  // R11
  irq_b_or_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq_b == (|$past(stat_b & en_b))));

endmodule

bind pin_irq_unit pin_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pins_in (pins_in),
  .mode_q  (mode_q),
  .pol_q   (pol_q),
  .edge_hit(edge_hit),
  .clr_a   (clr_mask[0]),
  .stat_a  (stat_q[0]),
  .stat_b  (stat_q[1]),
  .en_a    (en_q[0]),
  .en_b    (en_q[1]),
  .irq_a   (irq_a),
  .irq_b   (irq_b)
);

// File: tb/pin_irq_unit_tb.sv
module pin_irq_unit_tb;
  import pin_irq_pkg::*;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pins_in = '0;
  logic         bus_wr = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] d;

  always #5 clk = ~clk;

  pin_irq_unit #(.NUM_PINS(W)) u_dut (
    .clk(clk), .rst(rst), .pins_in(pins_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  // {kind, sense, pin before, pin after, expected status}
  localparam logic [4:0] VEC [9] = '{
    5'b0_0_0_1_1,  // level high, goes high
    5'b0_0_1_0_0,  // level high, goes low
    5'b0_1_1_0_1,  // level low, goes low
    5'b0_1_0_1_0,  // level low, goes high
    5'b1_0_0_1_1,  // rising edge
    5'b1_0_1_0_0,  // falling under rise sense
    5'b1_1_1_0_1,  // falling edge
    5'b1_1_0_1_0,  // rising under fall sense
    5'b1_0_1_1_0   // no transition
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] v);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    rd(SEL_MODE, d);   chk("R1 kind", d, '0);
    rd(SEL_POL, d);    chk("R1 sense", d, '0);
    rd(SEL_EN_A, d);   chk("R1 enable A", d, '0);
    rd(SEL_EN_B, d);   chk("R1 enable B", d, '0);
    rd(SEL_STAT_A, d); chk("R1 status A", d, '0);
    rd(SEL_STAT_B, d); chk("R1 status B", d, '0);
    chk("R1 irq_a", W'(irq_a), '0);
    chk("R1 irq_b", W'(irq_b), '0);

    // R2 R3 table walk on pin 0, line A
    wr(SEL_EN_A, 32'h1);
    for (int i = 0; i < 9; i++) begin
      wr(SEL_MODE, {31'b0, VEC[i][4]});
      wr(SEL_POL,  {31'b0, VEC[i][3]});
      pins_in[0] = VEC[i][2];
      tick(2);
      wr(SEL_STAT_A, 32'h1);
      pins_in[0] = VEC[i][1];
      tick(1);
      rd(SEL_STAT_A, d);
      chk(VEC[i][4] ? "R3 edge status" : "R2 level status", W'(d[0]), W'(VEC[i][0]));
      chk("R10 irq_a follows", W'(irq_a), W'(VEC[i][0]));
    end

    // R4 R5 R7 on pin 0, all pins edge rising
    wr(SEL_MODE, '1);
    wr(SEL_POL, '0);
    pins_in = '0;
    tick(2);
    wr(SEL_STAT_A, '1);
    wr(SEL_STAT_B, '1);
    pins_in[0] = 1'b1; tick(1);
    pins_in[0] = 1'b0; tick(1);
    rd(SEL_STAT_A, d); chk("R4 sticky after return", d, 32'h1);
    wr(SEL_STAT_A, 32'h0);
    rd(SEL_STAT_A, d); chk("R5 zero write keeps", d, 32'h1);
    wr(SEL_STAT_A, 32'h1);
    rd(SEL_STAT_A, d); chk("R5 one write clears", d, 32'h0);
    pins_in[0] = 1'b1;
    wr(SEL_STAT_A, 32'h1);
    rd(SEL_STAT_A, d); chk("R7 edge beats clear", d, 32'h1);

    // R6 level pin 1, high active
    wr(SEL_MODE, 32'hFFFF_FFFD);
    wr(SEL_SET_A, 32'h2);
    pins_in[1] = 1'b1; tick(1);
    wr(SEL_STAT_A, 32'h2);
    rd(SEL_STAT_A, d); chk("R6 clear futile while active", W'(d[1]), W'(1));
    pins_in[1] = 1'b0; tick(1);
    rd(SEL_STAT_A, d); chk("R6 drops when inactive", W'(d[1]), W'(0));

    // R9 R11 disabled capture on pin 2, line B only
    wr(SEL_STAT_A, '1);
    wr(SEL_STAT_B, '1);
    pins_in[2] = 1'b1; tick(1);
    rd(SEL_STAT_B, d); chk("R9 disabled reads 0", d, 32'h0);
    wr(SEL_SET_B, 32'h4);
    rd(SEL_STAT_B, d); chk("R9 recorded then enabled", d, 32'h4);
    tick(1);
    chk("R11 irq_b raised", W'(irq_b), W'(1));
    chk("R11 irq_a untouched", W'(irq_a), W'(0));
    rd(SEL_STAT_A, d); chk("R11 status A untouched", d, 32'h0);

    // R8 enable mask forms
    wr(SEL_EN_A, 32'hF0);
    wr(SEL_SET_A, 32'h3);
    wr(SEL_CLR_A, 32'h30);
    rd(SEL_EN_A, d);  chk("R8 mask A combined", d, 32'hC3);
    rd(SEL_SET_A, d); chk("R8 set select reads 0", d, 32'h0);
    wr(SEL_SET_B, 32'h8000_0000);
    rd(SEL_EN_B, d);  chk("R8 single pin B", d, 32'h8000_0004);
    wr(SEL_CLR_B, 32'h4);
    rd(SEL_EN_B, d);  chk("R8 clear single pin B", d, 32'h8000_0000);

    // R10 line falls after clear
    wr(SEL_SET_B, 32'h4);
    wr(SEL_STAT_B, '1);
    tick(1);
    chk("R10 irq_b low after clear", W'(irq_b), W'(0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule